// File: doc/BRIEF.md
# CPU Interrupt Acceptance and Restart Vector Unit

This unit is the interrupt-acceptance slice of an 8-bit processor core. The instruction decoder reports each retiring instruction with a boundary strobe and one decoded event flag. The flag can be enable, disable, return-from-NMI, return-from-interrupt, or a restart opcode with its byte. The unit keeps a main interrupt-enable bit and a saved copy of it. Enabling is held back by one instruction, so a maskable request cannot be taken at the boundary of the enable instruction itself. The non-maskable return puts back the enable state that was in force when the non-maskable interrupt was entered.

At each boundary the unit decides whether to accept a pending non-maskable request or a maskable request. It produces a one-cycle pulse for whichever it accepts. It also produces a jump target for the non-maskable entry and for restart opcodes. A return-from-interrupt produces a one-cycle completion pulse, so that daisy-chained peripherals can release lower-priority sources. All outputs are registered and appear in the cycle after the boundary that caused them. Pushing the return address and full instruction decoding belong to the surrounding core.

Top module: `irq_accept_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every output is 0. Reset also discards a latched non-maskable request.
- R2: At a boundary, a restart event with `op_byte` of the form 11fff111 gives `vec_valid`=1 and `vec_addr`=fff×8 (C7h gives 0000h, FFh gives 0038h). Any other byte gives no vector. `vec_addr` is 0 whenever `vec_valid` is 0.
- R3: A `nmi_edge` pulse is held until the next boundary, including the boundary in the same cycle. That boundary gives `nmi_taken`=1, `vec_valid`=1 and `vec_addr`=0066h. The non-maskable request wins over a maskable request at the same boundary, and `irq_taken` stays 0.
- R4: An enable event at a boundary sets both enable bits. `int_req` is not accepted at that same boundary. It can be accepted at the next boundary.
- R5: A disable event at a boundary clears both enable bits, and no maskable request is accepted at that boundary.
- R6: At a boundary with `int_req`=1 and the main enable set, `irq_taken` pulses for one cycle and both enable bits are cleared.
- R7: On taking the non-maskable interrupt, the saved enable takes the main enable value (after any event at the same boundary), and the main enable is cleared.
- R8: A non-maskable return event at a boundary copies the saved enable into the main enable.
- R9: A return-from-interrupt event at a boundary makes `reti_done` 1 for one cycle and leaves both enable bits unchanged.
- R10: Event flags and `int_req` have no effect in a cycle where `boundary` is 0. Only `nmi_edge` is latched in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | An instruction retires this cycle |
| ev_ei | input | 1 | Retiring instruction is the enable instruction |
| ev_di | input | 1 | Retiring instruction is the disable instruction |
| ev_retn | input | 1 | Retiring instruction is the non-maskable return |
| ev_reti | input | 1 | Retiring instruction is the return from interrupt |
| ev_rst | input | 1 | Retiring instruction is a restart opcode |
| op_byte | input | 8 | Opcode byte accompanying `ev_rst` |
| int_req | input | 1 | Maskable interrupt request level |
| nmi_edge | input | 1 | One-cycle pulse on a non-maskable request edge |
| irq_taken | output | 1 | Maskable interrupt accepted (pulse) |
| nmi_taken | output | 1 | Non-maskable interrupt accepted (pulse) |
| vec_valid | output | 1 | `vec_addr` holds a jump target (pulse) |
| vec_addr | output | 16 | Jump target address |
| reti_done | output | 1 | Return-from-interrupt completion pulse |
| ie_main | output | 1 | Main interrupt enable |
| ie_saved | output | 1 | Saved interrupt enable |

## Verification
The properties assume that the decoder raises at most one event flag per cycle, and that event flags only matter together with `boundary`. The random stimulus therefore picks a single event kind, or none, in each cycle. It also drives events in cycles without a boundary, so that the ignore rule is exercised against that assumption. `nmi_edge` is kept sparse so that latched and same-cycle requests both occur. Restart bytes are biased toward the valid form while still covering invalid bytes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W_DEF  = 16;
  localparam int OP_W_DEF    = 8;
  localparam int NMI_ADDR_DEF = 'h0066;
  // restart opcode layout: fixed high pair, target field, fixed low triple
  localparam int RST_FLD_LSB = 3;
  localparam int RST_FLD_W   = 3;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic boundary,
  input  logic nmi_edge,
  output logic nmi_hit
);
  logic pend_q;

  assign nmi_hit = boundary & (pend_q | nmi_edge);

  always_ff @(posedge clk) begin
    if (rst)          pend_q <= 1'b0;
    else if (nmi_hit) pend_q <= 1'b0;
    else if (nmi_edge) pend_q <= 1'b1;
  end
endmodule

// File: rtl/irq_enable_ff.sv
module irq_enable_ff (
  input  logic clk,
  input  logic rst,
  input  logic boundary,
  input  logic ev_ei,
  input  logic ev_di,
  input  logic ev_retn,
  input  logic take_nmi,
  input  logic take_irq,
  output logic mask_open,
  output logic ie_main_q,
  output logic ie_saved_q
);
  logic main_evt, saved_evt;

  // enable state after the retiring instruction's own effect
  always_comb begin
    main_evt  = ie_main_q;
    saved_evt = ie_saved_q;
    if (boundary) begin
      if (ev_di) begin
        main_evt  = 1'b0;
        saved_evt = 1'b0;
      end else if (ev_ei) begin
        main_evt  = 1'b1;
        saved_evt = 1'b1;
      end else if (ev_retn) begin
        main_evt  = ie_saved_q;
      end
    end
  end

  // the enable instruction's own boundary stays closed
  assign mask_open = boundary & main_evt & ~ev_ei;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_main_q  <= 1'b0;
      ie_saved_q <= 1'b0;
    end else if (take_nmi) begin
      ie_saved_q <= main_evt;
      ie_main_q  <= 1'b0;
    end else if (take_irq) begin
      ie_saved_q <= 1'b0;
      ie_main_q  <= 1'b0;
    end else begin
      ie_main_q  <= main_evt;
      ie_saved_q <= saved_evt;
    end
  end
endmodule

// File: rtl/irq_rst_decode.sv
module irq_rst_decode #(
  parameter int OP_W   = irq_pkg::OP_W_DEF,
  parameter int ADDR_W = irq_pkg::ADDR_W_DEF
) (
  input  logic [OP_W-1:0]   op_byte,
  output logic              is_rst,
  output logic [ADDR_W-1:0] target
);
  localparam int LSB   = irq_pkg::RST_FLD_LSB;
  localparam int FW    = irq_pkg::RST_FLD_W;
  localparam int MSB   = LSB + FW - 1;
  localparam int HI_W  = OP_W - MSB - 1;
  localparam int PAD_W = ADDR_W - FW - LSB;

  assign is_rst = (&op_byte[OP_W-1 -: HI_W]) & (&op_byte[LSB-1:0]);
  assign target = {{PAD_W{1'b0}}, op_byte[MSB:LSB], {LSB{1'b0}}};
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl #(
  parameter int ADDR_W = irq_pkg::ADDR_W_DEF,
  parameter int OP_W   = irq_pkg::OP_W_DEF,
  parameter logic [ADDR_W-1:0] NMI_ADDR = ADDR_W'(irq_pkg::NMI_ADDR_DEF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary,
  input  logic              ev_ei,
  input  logic              ev_di,
  input  logic              ev_retn,
  input  logic              ev_reti,
  input  logic              ev_rst,
  input  logic [OP_W-1:0]   op_byte,
  input  logic              int_req,
  input  logic              nmi_edge,
  output logic              irq_taken,
  output logic              nmi_taken,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              reti_done,
  output logic              ie_main,
  output logic              ie_saved
);
  logic nmi_hit, mask_open, take_irq, rst_ok;
  logic [ADDR_W-1:0] rst_tgt;

  irq_nmi_latch u_nmi (
    .clk(clk), .rst(rst), .boundary(boundary),
    .nmi_edge(nmi_edge), .nmi_hit(nmi_hit)
  );

  assign take_irq = mask_open & int_req & ~nmi_hit;

  irq_enable_ff u_ie (
    .clk(clk), .rst(rst), .boundary(boundary),
    .ev_ei(ev_ei), .ev_di(ev_di), .ev_retn(ev_retn),
    .take_nmi(nmi_hit), .take_irq(take_irq),
    .mask_open(mask_open), .ie_main_q(ie_main), .ie_saved_q(ie_saved)
  );

  irq_rst_decode #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_dec (
    .op_byte(op_byte), .is_rst(rst_ok), .target(rst_tgt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_taken <= 1'b0;
      nmi_taken <= 1'b0;
      vec_valid <= 1'b0;
      vec_addr  <= '0;
      reti_done <= 1'b0;
    end else begin
      irq_taken <= take_irq;
      nmi_taken <= nmi_hit;
      reti_done <= boundary & ev_reti;
      if (nmi_hit) begin
        vec_valid <= 1'b1;
        vec_addr  <= NMI_ADDR;
      end else if (boundary & ev_rst & rst_ok) begin
        vec_valid <= 1'b1;
        vec_addr  <= rst_tgt;
      end else begin
        vec_valid <= 1'b0;
        vec_addr  <= '0;
      end
    end
  end
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] NMI_ADDR = 'h66
) (
  input logic              clk,
  input logic              rst,
  input logic              boundary,
  input logic              ev_ei,
  input logic              ev_di,
  input logic              ev_retn,
  input logic              ev_reti,
  input logic              ev_rst,
  input logic              irq_taken,
  input logic              nmi_taken,
  input logic              vec_valid,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              reti_done,
  input logic              ie_main,
  input logic              ie_saved
);
  // R10 (input assumption: one event flag per cycle)
  one_event_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_ei, ev_di, ev_retn, ev_reti, ev_rst}));

  // R3
  nmi_vector_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_taken |-> (vec_valid && vec_addr == NMI_ADDR));

  // R3
  nmi_priority_chk: assert property (@(posedge clk) disable iff (rst)
    !(nmi_taken && irq_taken));

  // R4
  ei_shadow_chk: assert property (@(posedge clk) disable iff (rst)
    (boundary && ev_ei) |=> !irq_taken);

  // R5
  di_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (boundary && ev_di) |=> (!ie_main && !ie_saved && !irq_taken));

  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    irq_taken |-> (!ie_main && !ie_saved));

  // R7
  nmi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_taken |-> !ie_main);

  // R9
  reti_source_chk: assert property (@(posedge clk) disable iff (rst)
    reti_done |-> $past(boundary && ev_reti));

  // R10
  no_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> (!irq_taken && !reti_done));
endmodule

bind irq_accept_ctrl irq_accept_chk #(.ADDR_W(ADDR_W), .NMI_ADDR(NMI_ADDR)) u_chk (
  .clk(clk), .rst(rst), .boundary(boundary),
  .ev_ei(ev_ei), .ev_di(ev_di), .ev_retn(ev_retn), .ev_reti(ev_reti), .ev_rst(ev_rst),
  .irq_taken(irq_taken), .nmi_taken(nmi_taken), .vec_valid(vec_valid),
  .vec_addr(vec_addr), .reti_done(reti_done), .ie_main(ie_main), .ie_saved(ie_saved)
);

// File: tb/sim_irq_accept_ctrl.sv
module sim_irq_accept_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, boundary, ev_ei, ev_di, ev_retn, ev_reti, ev_rst, int_req, nmi_edge;
  logic [7:0]  op_byte;
  logic        irq_taken, nmi_taken, vec_valid, reti_done, ie_main, ie_saved;
  logic [15:0] vec_addr;

  irq_accept_ctrl u0 (
    .clk(clk), .rst(rst), .boundary(boundary), .ev_ei(ev_ei), .ev_di(ev_di),
    .ev_retn(ev_retn), .ev_reti(ev_reti), .ev_rst(ev_rst), .op_byte(op_byte),
    .int_req(int_req), .nmi_edge(nmi_edge), .irq_taken(irq_taken),
    .nmi_taken(nmi_taken), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .reti_done(reti_done), .ie_main(ie_main), .ie_saved(ie_saved)
  );

  int n_run = 0, n_fail = 0;
  bit m_main, m_saved, m_pend;
  bit e_irq, e_nmi, e_vv, e_reti;
  logic [15:0] e_va;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rst_target(logic [7:0] op);
    return {10'd0, op[5:3], 3'd0};
  endfunction

  // expected outputs and next state from the requirements
  task automatic model();
    bit me, se, nh, ih, ro;
    me = m_main; se = m_saved;
    if (boundary) begin
      if (ev_di) begin me = 0; se = 0; end          // R5
      else if (ev_ei) begin me = 1; se = 1; end     // R4
      else if (ev_retn) me = m_saved;               // R8
    end
    nh = boundary && (m_pend || nmi_edge);          // R3
    ih = boundary && me && !ev_ei && int_req && !nh; // R6
    ro = boundary && ev_rst && op_byte[7:6] == 2'b11 && op_byte[2:0] == 3'b111; // R2
    e_nmi = nh; e_irq = ih; e_reti = boundary && ev_reti;
    e_vv = nh || ro;
    e_va = nh ? 16'h0066 : (ro ? rst_target(op_byte) : 16'h0);
    if (nh) m_pend = 0; else if (nmi_edge) m_pend = 1;
    if (nh) begin m_saved = me; m_main = 0; end     // R7
    else if (ih) begin m_main = 0; m_saved = 0; end
    else begin m_main = me; m_saved = se; end
  endtask

  task automatic compare_all();
    chk("R6 irq_taken", irq_taken, e_irq);
    chk("R3 nmi_taken", nmi_taken, e_nmi);
    chk("R2 vec_valid", vec_valid, e_vv);
    chk("R2 vec_addr", vec_addr, e_va);
    chk("R9 reti_done", reti_done, e_reti);
    chk("R7 ie_main", ie_main, m_main);
    chk("R7 ie_saved", ie_saved, m_saved);
  endtask

  // kind: 0 none,1 ei,2 di,3 retn,4 reti,5 restart
  task automatic cyc(bit b, int kind, logic [7:0] op, bit irq, bit nmi);
    @(negedge clk);
    boundary = b; ev_ei = (kind == 1); ev_di = (kind == 2); ev_retn = (kind == 3);
    ev_reti = (kind == 4); ev_rst = (kind == 5); op_byte = op;
    int_req = irq; nmi_edge = nmi;
    model();
    @(posedge clk); #1;
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; boundary = 0; ev_ei = 0; ev_di = 0; ev_retn = 0; ev_reti = 0;
    ev_rst = 0; op_byte = 0; int_req = 0; nmi_edge = 0;
    repeat (2) @(posedge clk);
    #1;
    m_main = 0; m_saved = 0; m_pend = 0;
    e_irq = 0; e_nmi = 0; e_vv = 0; e_va = 0; e_reti = 0;
    // R1 reset state
    chk("R1 irq_taken", irq_taken, 0); chk("R1 vec_valid", vec_valid, 0);
    chk("R1 ie_main", ie_main, 0);     chk("R1 ie_saved", ie_saved, 0);
    @(negedge clk); rst = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R2 restart targets and an invalid byte
    cyc(1, 5, 8'hC7, 0, 0); chk("R2 C7 target", vec_addr, 16'h0000);
    cyc(1, 5, 8'hFF, 0, 0); chk("R2 FF target", vec_addr, 16'h0038);
    cyc(1, 5, 8'hC6, 0, 0); chk("R2 invalid byte", vec_valid, 0);
    // R4 enable delay
    cyc(1, 1, 0, 1, 0); chk("R4 blocked at EI", irq_taken, 0);
    cyc(1, 0, 0, 1, 0); chk("R4 taken after next", irq_taken, 1);
    chk("R6 enables cleared", ie_main, 0);
    // R10 events without boundary
    cyc(0, 1, 0, 0, 0); chk("R10 EI ignored", ie_main, 0);
    // R5 disable
    cyc(1, 1, 0, 0, 0); cyc(1, 2, 0, 1, 0); chk("R5 DI blocks", irq_taken, 0);
    // R7/R8 NMI with enable set, then retn restores
    cyc(1, 1, 0, 0, 0); cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1); chk("R3 latched not taken", nmi_taken, 0);
    cyc(1, 0, 0, 1, 0); chk("R3 priority over irq", irq_taken, 0);
    chk("R7 saved copy", ie_saved, 1);
    cyc(1, 3, 0, 0, 0); chk("R8 restored", ie_main, 1);
    // R8 NMI with enable clear
    cyc(1, 2, 0, 0, 0); cyc(1, 0, 0, 0, 1); cyc(1, 3, 0, 0, 0);
    chk("R8 stays clear", ie_main, 0);
    // R9 completion pulse
    cyc(1, 4, 0, 0, 0); chk("R9 pulse", reti_done, 1);
    cyc(1, 0, 0, 0, 0); chk("R9 one cycle", reti_done, 0);
    // R1 reset drops a latched NMI
    cyc(0, 0, 0, 0, 1); do_reset();
    cyc(1, 0, 0, 0, 0); chk("R1 pending cleared", nmi_taken, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [7:0] op;
      k = int'($urandom % 9);
      if (k > 5) k = 0;
      op = ($urandom % 2 == 0) ? {2'b11, 3'($urandom), 3'b111} : 8'($urandom);
      cyc($urandom % 3 != 0, k, op, $urandom % 2 == 0, $urandom % 12 == 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule